// File: doc/BRIEF.md
# Secure Memory Region Access Filter

This block decides, for each memory transaction presented to it, whether the transaction may proceed. It holds a small table of programmable address regions. Each region has an inclusive address window, a bitmap of the filter ports it applies to, a 2-bit permission code for secure accesses and a per-master permission word for non-secure accesses. Region 0 is a fixed background region that spans the whole address space on every filter. Only its permissions can be programmed.

A transaction is presented on the check port as an address, a read/write flag, a secure flag, a master number and a filter number. The highest-numbered region that applies to that filter and contains the address decides the outcome. The permit/deny answer is registered and appears one clock later.

A word-addressed register port programs the regions and returns their contents. The same port reports the build configuration and a fixed identification value.

Top module: `sec_region_filter`

## Requirements
- R1: After reset every region other than region 0 reads back base 0, top 0x0000_0FFF, attribute 0 and access word 0, and every region's permissions are zero, so every check is denied.
- R2: Word address 0 reads the build configuration: bits [25:24] hold the filter count minus one, bits [12:8] the region count minus one, bits [7:0] the address width minus one, and all other bits are zero (0x0300_0827 for 4 filters, 9 regions, 40-bit addresses).
- R3: Word addresses 4, 5, 6 and 7 each read one byte of the identification value 0xB105F00D in bits [7:0], least significant byte at address 4, with bits [31:8] zero.
- R4: Region r occupies word addresses 16+8r+k, where k=0 is base low, k=1 base high, k=2 top low, k=3 top high, k=4 attribute and k=5 access word. Base low always reads with bits [11:0] zero, and top low always reads with bits [11:0] set, whatever was written.
- R5: Address bits at and above the configured address width read back as zero and take no part in matching.
- R6: Writes to region 0's base, top or filter bitmap are ignored. Region 0 always reads base 0, top equal to the all-ones address, and a bitmap with every filter bit set.
- R7: The permission code and the access word of region 0 remain writable.
- R8: A region applies to a check only when bit f of its attribute word (bits [NUM_FILTERS-1:0]) is set for filter f, and base <= address <= top with both bounds inclusive.
- R9: When several regions apply to a check, the highest-numbered one decides the outcome.
- R10: For a secure check, the attribute bits [31:30] of the deciding region form the permission code: 0 denies everything, 1 permits reads only, 2 permits writes only and 3 permits both.
- R11: For a non-secure check by master m, a read is permitted only if bit m of the deciding region's access word is set, and a write only if bit 16+m is set. The secure permission code has no effect on non-secure checks.
- R12: The response valid flag rises exactly one clock after a check is presented and is low otherwise. The permit output is low whenever the response valid flag is low.
- R13: Writes to region slots at or beyond the configured region count are ignored, and reads from them return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| regAddr | input | REG_AW | Register word address |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for regAddr (combinational) |
| chkValid | input | 1 | Check request present |
| chkAddr | input | ADDR_W | Transaction address |
| chkWrite | input | 1 | 1 = write, 0 = read |
| chkSecure | input | 1 | 1 = secure transaction |
| chkMaster | input | MID_W | Master number |
| chkFilter | input | FILT_W | Filter port number |
| chkRespValid | output | 1 | Check result valid, one clock after request |
| chkPermit | output | 1 | 1 = transaction permitted |

## Verification
The bench targets inclusive window edges: the first and last byte of a region, and one byte past the top. A design that uses strict comparisons, or forgets the implicit 0xFFF on top, permits or denies the wrong edge byte. Overlapping windows on the same filter are checked against the numbering priority. A design that lets the lowest-numbered region win would permit where the higher region denies. Region 0 write protection is checked, as is the independence of the secure code from the non-secure access word. A design that mixes them would let a non-secure master through on a secure-only permission. An address above 4 GiB exercises the high half of the comparison, and writes to a nonexistent slot confirm that they leave nothing readable behind.

// File: rtl/secfilt_pkg.sv
package secfilt_pkg;
  localparam int RIDX_W = 5;
  localparam int PERM_LSB = 30;
  localparam logic [31:0] ID_VALUE = 32'hB105_F00D;

  typedef enum logic [3:0] {
    FLD_NONE, FLD_BUILD, FLD_IDENT, FLD_BASE_LO, FLD_BASE_HI,
    FLD_TOP_LO, FLD_TOP_HI, FLD_ATTR, FLD_ACCESS
  } fld_e;

  typedef struct packed {
    logic             wr;
    fld_e             fld;
    logic [RIDX_W-1:0] region;
    logic [1:0]       idByte;
  } regStrb_t;
endpackage

// File: rtl/secfilt_ctrl.sv
module secfilt_ctrl
  import secfilt_pkg::*;
#(
  parameter int REG_AW      = 8,
  parameter int NUM_REGIONS = 9
) (
  input  logic [REG_AW-1:0] regAddr,
  input  logic              regWrEn,
  output regStrb_t          strb
);
  logic [REG_AW-1:0] offs;
  logic [REG_AW-1:0] slot;

  assign offs = regAddr - REG_AW'(16);
  assign slot = offs >> 3;

  always_comb begin
    strb        = '0;
    strb.fld    = FLD_NONE;
    strb.wr     = regWrEn;
    strb.idByte = regAddr[1:0];
    strb.region = RIDX_W'(slot);
    if (regAddr == '0) begin
      strb.fld = FLD_BUILD;
    end else if (regAddr >= REG_AW'(4) && regAddr <= REG_AW'(7)) begin
      strb.fld = FLD_IDENT;
    end else if (regAddr >= REG_AW'(16) && 32'(slot) < NUM_REGIONS) begin
      case (offs[2:0])
        3'd0:    strb.fld = FLD_BASE_LO;
        3'd1:    strb.fld = FLD_BASE_HI;
        3'd2:    strb.fld = FLD_TOP_LO;
        3'd3:    strb.fld = FLD_TOP_HI;
        3'd4:    strb.fld = FLD_ATTR;
        3'd5:    strb.fld = FLD_ACCESS;
        default: strb.fld = FLD_NONE;
      endcase
    end
  end
endmodule

// File: rtl/secfilt_dp.sv
module secfilt_dp
  import secfilt_pkg::*;
#(
  parameter int NUM_FILTERS = 4,
  parameter int NUM_REGIONS = 9,
  parameter int ADDR_W      = 40,
  parameter int NUM_MASTERS = 16,
  parameter int FILT_W      = 2,
  parameter int MID_W       = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  regStrb_t          strb,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic              chkValid,
  input  logic [ADDR_W-1:0] chkAddr,
  input  logic              chkWrite,
  input  logic              chkSecure,
  input  logic [MID_W-1:0]  chkMaster,
  input  logic [FILT_W-1:0] chkFilter,
  output logic              chkRespValid,
  output logic              chkPermit
);
  localparam logic [63:0] ADDR_MASK = (ADDR_W >= 64) ? {64{1'b1}}
                                      : ((64'd1 << ADDR_W) - 64'd1);
  localparam logic [31:0] LO_PAGE = 32'h0000_0FFF;

  logic [63:0]            baseV [NUM_REGIONS];
  logic [63:0]            topV  [NUM_REGIONS];
  logic [NUM_FILTERS-1:0] fenV  [NUM_REGIONS];
  logic [1:0]             permV [NUM_REGIONS];
  logic [31:0]            accV  [NUM_REGIONS];

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_rgn
    logic       hit;
    logic [1:0] permR;
    logic [31:0] accR;
    assign hit = strb.wr && (strb.region == RIDX_W'(r));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        permR <= '0;
        accR  <= '0;
      end else if (hit) begin
        if (strb.fld == FLD_ATTR)   permR <= regWrData[PERM_LSB+1:PERM_LSB];
        if (strb.fld == FLD_ACCESS) accR  <= regWrData;
      end
    end
    assign permV[r] = permR;
    assign accV[r]  = accR;

    if (r == 0) begin : g_fixed
      assign baseV[r] = '0;
      assign topV[r]  = ADDR_MASK;
      assign fenV[r]  = '1;
    end else begin : g_prog
      logic [63:0]            baseR, topR;
      logic [NUM_FILTERS-1:0] fenR;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          baseR <= '0;
          topR  <= 64'(LO_PAGE);
          fenR  <= '0;
        end else if (hit) begin
          case (strb.fld)
            FLD_BASE_LO: baseR[31:0]  <= regWrData & ADDR_MASK[31:0] & ~LO_PAGE;
            FLD_BASE_HI: baseR[63:32] <= regWrData & ADDR_MASK[63:32];
            FLD_TOP_LO:  topR[31:0]   <= (regWrData | LO_PAGE) & ADDR_MASK[31:0];
            FLD_TOP_HI:  topR[63:32]  <= regWrData & ADDR_MASK[63:32];
            FLD_ATTR:    fenR         <= regWrData[NUM_FILTERS-1:0];
            default: ;
          endcase
        end
      end
      assign baseV[r] = baseR;
      assign topV[r]  = topR;
      assign fenV[r]  = fenR;
    end
  end

  // Register readback
  always_comb begin
    int ri;
    ri = int'(strb.region);
    regRdData = '0;
    if (ri < NUM_REGIONS) begin
      case (strb.fld)
        FLD_BASE_LO: regRdData = baseV[ri][31:0];
        FLD_BASE_HI: regRdData = baseV[ri][63:32];
        FLD_TOP_LO:  regRdData = topV[ri][31:0];
        FLD_TOP_HI:  regRdData = topV[ri][63:32];
        FLD_ATTR: begin
          regRdData = 32'(fenV[ri]);
          regRdData[PERM_LSB+1:PERM_LSB] = permV[ri];
        end
        FLD_ACCESS:  regRdData = accV[ri];
        default: ;
      endcase
    end
    if (strb.fld == FLD_BUILD)
      regRdData = {6'b0, 2'(NUM_FILTERS-1), 11'b0, 5'(NUM_REGIONS-1), 8'(ADDR_W-1)};
    else if (strb.fld == FLD_IDENT)
      regRdData = {24'b0, ID_VALUE[8*strb.idByte +: 8]};
  end

  // Region match with highest-index priority, then permission decision
  logic [63:0] addrX;
  logic        allow;
  assign addrX = 64'(chkAddr);

  always_comb begin
    int win;
    int fi;
    int mi;
    win = 0;
    fi  = int'(chkFilter);
    mi  = int'(chkMaster);
    for (int r = 0; r < NUM_REGIONS; r++) begin
      if (fi < NUM_FILTERS && fenV[r][fi] && addrX >= baseV[r] && addrX <= topV[r])
        win = r;
    end
    if (chkSecure)
      allow = chkWrite ? permV[win][1] : permV[win][0];
    else if (mi < NUM_MASTERS)
      allow = chkWrite ? accV[win][16+mi] : accV[win][mi];
    else
      allow = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chkRespValid <= 1'b0;
      chkPermit    <= 1'b0;
    end else begin
      chkRespValid <= chkValid;
      chkPermit    <= chkValid && allow;
    end
  end
endmodule

// File: rtl/sec_region_filter.sv
module sec_region_filter
  import secfilt_pkg::*;
#(
  parameter int NUM_FILTERS = 4,
  parameter int NUM_REGIONS = 9,
  parameter int ADDR_W      = 40,
  parameter int NUM_MASTERS = 16,
  parameter int REG_AW      = 8,
  localparam int FILT_W     = (NUM_FILTERS > 1) ? $clog2(NUM_FILTERS) : 1,
  localparam int MID_W      = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic              chkValid,
  input  logic [ADDR_W-1:0] chkAddr,
  input  logic              chkWrite,
  input  logic              chkSecure,
  input  logic [MID_W-1:0]  chkMaster,
  input  logic [FILT_W-1:0] chkFilter,
  output logic              chkRespValid,
  output logic              chkPermit
);
  regStrb_t strb;

  secfilt_ctrl #(.REG_AW(REG_AW), .NUM_REGIONS(NUM_REGIONS)) ctrl_i (
    .regAddr(regAddr), .regWrEn(regWrEn), .strb(strb)
  );

  secfilt_dp #(
    .NUM_FILTERS(NUM_FILTERS), .NUM_REGIONS(NUM_REGIONS), .ADDR_W(ADDR_W),
    .NUM_MASTERS(NUM_MASTERS), .FILT_W(FILT_W), .MID_W(MID_W)
  ) dp_i (
    .clk(clk), .rst_n(rst_n), .strb(strb), .regWrData(regWrData),
    .regRdData(regRdData), .chkValid(chkValid), .chkAddr(chkAddr),
    .chkWrite(chkWrite), .chkSecure(chkSecure), .chkMaster(chkMaster),
    .chkFilter(chkFilter), .chkRespValid(chkRespValid), .chkPermit(chkPermit)
  );
endmodule

// File: rtl/sec_region_filter_chk.sv
module sec_region_filter_chk #(
  parameter int NUM_REGIONS = 9,
  parameter int REG_AW      = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [REG_AW-1:0] regAddr,
  input logic [31:0]       regRdData,
  input logic              chkValid,
  input logic              chkRespValid,
  input logic              chkPermit
);
  AST_RESP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    chkValid |=> chkRespValid); // R12
  AST_RESP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !chkValid |=> !chkRespValid); // R12
  AST_PERMIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !chkRespValid |-> !chkPermit); // R12
  AST_IDENT_BYTE0: assert property (@(posedge clk) disable iff (!rst_n)
    (regAddr == REG_AW'(4)) |-> (regRdData == 32'h0000_000D)); // R3
  AST_BG_BASE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (regAddr == REG_AW'(16) || regAddr == REG_AW'(17)) |-> (regRdData == 32'h0)); // R6
  AST_TOP_PAGE_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (regAddr >= REG_AW'(16) && 32'(regAddr) < 16 + 8*NUM_REGIONS && regAddr[2:0] == 3'd2)
      |-> (regRdData[11:0] == 12'hFFF)); // R4
endmodule

bind sec_region_filter sec_region_filter_chk #(
  .NUM_REGIONS(NUM_REGIONS), .REG_AW(REG_AW)
) chk_i (
  .clk(clk), .rst_n(rst_n), .regAddr(regAddr), .regRdData(regRdData),
  .chkValid(chkValid), .chkRespValid(chkRespValid), .chkPermit(chkPermit)
);

// File: tb/sec_region_filter_tb_top.sv
module sec_region_filter_tb_top;
  localparam int AW = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        chkValid = 1'b0;
  logic [AW-1:0] chkAddr = '0;
  logic        chkWrite = 1'b0;
  logic        chkSecure = 1'b0;
  logic [3:0]  chkMaster = '0;
  logic [1:0]  chkFilter = '0;
  logic        chkRespValid, chkPermit;

  int nTests = 0;
  int nFail  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  sec_region_filter #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .chkValid(chkValid),
    .chkAddr(chkAddr), .chkWrite(chkWrite), .chkSecure(chkSecure),
    .chkMaster(chkMaster), .chkFilter(chkFilter),
    .chkRespValid(chkRespValid), .chkPermit(chkPermit)
  );

  function automatic logic [7:0] ra(int r, int k);
    return 8'(16 + 8*r + k);
  endfunction

  task automatic regWrite(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(logic [7:0] a, logic [31:0] exp, string req);
    @(negedge clk);
    regAddr = a;
    #1;
    nTests++;
    if (regRdData !== exp) begin
      nFail++;
      $display("FAIL %s: read addr %0d got %h expected %h", req, a, regRdData, exp);
    end
  endtask

  task automatic check(logic [63:0] a, logic wr, logic sec, int m, int f,
                       logic exp, string req);
    @(negedge clk);
    chkValid = 1'b1; chkAddr = a[AW-1:0]; chkWrite = wr; chkSecure = sec;
    chkMaster = 4'(m); chkFilter = 2'(f);
    @(negedge clk);
    chkValid = 1'b0;
    nTests++;
    if (chkRespValid !== 1'b1 || chkPermit !== exp) begin
      nFail++;
      $display("FAIL %s: addr %h wr %0d sec %0d got valid %b permit %b expected valid 1 permit %b",
               req, a, wr, sec, chkRespValid, chkPermit, exp);
    end
  endtask

  task automatic t_reset;
    regRead(ra(1, 0), 32'h0, "R1");
    regRead(ra(1, 2), 32'h0000_0FFF, "R1");
    regRead(ra(1, 4), 32'h0, "R1");
    regRead(ra(0, 5), 32'h0, "R1");
    check(64'h1000, 1'b0, 1'b1, 0, 0, 1'b0, "R1");
    check(64'h1000, 1'b0, 1'b0, 0, 0, 1'b0, "R1");
  endtask

  task automatic t_ident;
    regRead(8'd0, 32'h0300_0827, "R2");
    regRead(8'd4, 32'h0D, "R3");
    regRead(8'd5, 32'hF0, "R3");
    regRead(8'd6, 32'h05, "R3");
    regRead(8'd7, 32'hB1, "R3");
  endtask

  task automatic t_bounds;
    regWrite(ra(1, 0), 32'h1234_5ABC);
    regRead(ra(1, 0), 32'h1234_5000, "R4");
    regWrite(ra(1, 2), 32'h2000_0123);
    regRead(ra(1, 2), 32'h2000_0FFF, "R4");
    regWrite(ra(1, 1), 32'hFFFF_FF12);
    regRead(ra(1, 1), 32'h0000_0012, "R5");
  endtask

  task automatic t_background;
    regWrite(ra(0, 0), 32'hFFFF_F000);
    regWrite(ra(0, 3), 32'h0000_0001);
    regWrite(ra(0, 4), 32'hC000_0000);
    regRead(ra(0, 0), 32'h0, "R6");
    regRead(ra(0, 2), 32'hFFFF_FFFF, "R6");
    regRead(ra(0, 3), 32'h0000_00FF, "R6");
    regRead(ra(0, 4), 32'hC000_000F, "R7");
    regWrite(ra(0, 5), 32'h0001_0001);
    regRead(ra(0, 5), 32'h0001_0001, "R7");
    check(64'hFF_FFFF_FFFF, 1'b1, 1'b1, 0, 3, 1'b1, "R6");
  endtask

  task automatic t_secure;
    for (int c = 0; c < 4; c++) begin
      regWrite(ra(0, 4), 32'(c) << 30);
      check(64'h4000, 1'b0, 1'b1, 0, 0, c[0], "R10");
      check(64'h4000, 1'b1, 1'b1, 0, 2, c[1], "R10");
    end
  endtask

  task automatic t_nonsec;
    regWrite(ra(0, 4), 32'hC000_0000);
    regWrite(ra(0, 5), (32'd1 << 3) | (32'd1 << 21));
    check(64'h8000, 1'b0, 1'b0, 3, 0, 1'b1, "R11");
    check(64'h8000, 1'b1, 1'b0, 3, 0, 1'b0, "R11");
    check(64'h8000, 1'b1, 1'b0, 5, 1, 1'b1, "R11");
    check(64'h8000, 1'b0, 1'b0, 5, 1, 1'b0, "R11");
    check(64'h8000, 1'b0, 1'b0, 0, 1, 1'b0, "R11");
    regWrite(ra(0, 5), 32'h0);
  endtask

  task automatic t_match;
    regWrite(ra(1, 0), 32'h0001_0000); regWrite(ra(1, 1), 32'h0);
    regWrite(ra(1, 2), 32'h0001_F000); regWrite(ra(1, 3), 32'h0);
    regWrite(ra(1, 4), 32'hC000_0002);
    regWrite(ra(2, 0), 32'h0001_0000); regWrite(ra(2, 2), 32'h0001_FFFF);
    regWrite(ra(2, 4), 32'h0000_0002);
    check(64'h1_0000, 1'b0, 1'b1, 0, 1, 1'b0, "R9");
    check(64'h1_FFFF, 1'b0, 1'b1, 0, 1, 1'b0, "R8");
    check(64'h2_0000, 1'b0, 1'b1, 0, 1, 1'b1, "R8");
    check(64'h0_FFFF, 1'b0, 1'b1, 0, 1, 1'b1, "R8");
    check(64'h1_0000, 1'b0, 1'b1, 0, 0, 1'b1, "R8");
    regWrite(ra(3, 0), 32'h0001_8000); regWrite(ra(3, 2), 32'h0001_8000);
    regWrite(ra(3, 4), 32'hC000_0002);
    check(64'h1_8010, 1'b1, 1'b1, 0, 1, 1'b1, "R9");
    check(64'h1_9000, 1'b1, 1'b1, 0, 1, 1'b0, "R9");
    regWrite(ra(4, 0), 32'h0); regWrite(ra(4, 1), 32'h1);
    regWrite(ra(4, 2), 32'h0); regWrite(ra(4, 3), 32'h1);
    regWrite(ra(4, 4), 32'h0000_0001);
    check(64'h1_0000_0800, 1'b0, 1'b1, 0, 0, 1'b0, "R8");
    check(64'h0_0000_0800, 1'b0, 1'b1, 0, 0, 1'b1, "R5");
  endtask

  task automatic t_outrange;
    regWrite(8'h5C, 32'hC000_000F);
    regRead(8'h5C, 32'h0, "R13");
    regRead(8'h58, 32'h0, "R13");
    check(64'h1_9000, 1'b1, 1'b1, 0, 1, 1'b0, "R13");
  endtask

  task automatic t_latency;
    @(negedge clk);
    nTests++;
    if (chkRespValid !== 1'b0 || chkPermit !== 1'b0) begin
      nFail++;
      $display("FAIL R12: idle got valid %b permit %b expected 0 0", chkRespValid, chkPermit);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ident();
    t_bounds();
    t_background();
    t_secure();
    t_nonsec();
    t_match();
    t_outrange();
    t_latency();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!finished) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog: run did not end, got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule